// File: doc/BRIEF.md
# Dual-Loop Synthesizer Serial Register Loader

This block receives divider and configuration settings for a two-loop frequency synthesizer over a slow host-driven serial link. The host supplies a bit clock, a framing strobe and two data lines. All four lines are brought into the fast system clock domain through a synchronizer chain and edge-detected. The bit clock's rising edges shift data in, and the strobe's falling edge commits the collected bits to the output registers.

The strobe level while bits are shifted picks the destination. With the strobe high, a 32-bit word is collected. Its top bit then tells a control word (1) from a reference-divider word (0). With the strobe low, the transmit and receive divide values are collected. A stored select bit decides whether these come as one 32-bit stream on the main data line, or as two 16-bit streams: transmit on the auxiliary line and receive on the main line, clocked in parallel. Any frame with the wrong bit count, or shifted with a mix of strobe levels, is dropped and flagged with a single-cycle error pulse.

Top module: `synth_prog_loader`

## Requirements
- R1: After reset every output register is zero, the error pulse is low, and the auxiliary power-down output is high.
- R2: A data bit is taken on each rising edge of the serial clock, and the first bit sent lands in the most significant position of the word.
- R3: A frame of exactly 32 bits shifted with the strobe high, whose first bit is 1, is copied whole into the control word when the strobe falls.
- R4: A frame of exactly 32 bits shifted with the strobe high, whose first bit is 0, loads these fields when the strobe falls: bit 30 the auxiliary enable, bit 29 the reference select, bits 28:15 the 14-bit auxiliary divide value, bits 14:3 the 12-bit reference divide value. Bits 2:0 are ignored.
- R5: The auxiliary power-down output is high exactly when the stored auxiliary enable is 0.
- R6: While bit 0 of the control word is 0, a strobe-low frame of exactly 32 bits on the main data line loads its first 16 bits as the transmit value and its last 16 bits as the receive value.
- R7: While bit 0 of the control word is 1, a strobe-low frame of exactly 16 clocks loads the transmit value from the auxiliary line and the receive value from the main line, both taken in the same clocks.
- R8: A transmit/receive load leaves the control and reference registers unchanged, and a control or reference load leaves the transmit and receive values unchanged.
- R9: A frame whose bit count does not match its path and mode, or that was shifted with both strobe levels, changes no register and raises the error output for exactly one system cycle.
- R10: Registers change only after a strobe falling edge. A strobe pulse with no bits shifted since the last fall changes nothing and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rstN | input | 1 | Active-low asynchronous reset |
| serClk | input | 1 | Host serial bit clock |
| serEnb | input | 1 | Host framing strobe; its level selects the path and its fall commits |
| serData | input | 1 | Main serial data line |
| serAux | input | 1 | Auxiliary serial data line (transmit value in two-line mode) |
| ctrlWord | output | 32 | Stored control word; bit 0 selects two-line transmit/receive entry |
| refDiv | output | 12 | Reference divide value |
| auxDiv | output | 14 | Auxiliary reference divide value |
| refSel | output | 1 | Reference select bit |
| auxEn | output | 1 | Auxiliary reference enable |
| auxPowerDown | output | 1 | Power-down request for the auxiliary reference counter |
| txDiv | output | 16 | Transmit divide value |
| rxDiv | output | 16 | Receive divide value |
| loadErr | output | 1 | One-cycle pulse when a frame is discarded |

## Verification
The bench builds the block with the 32-bit word and 16-bit counters, and with three synchronizer stages instead of the default two. This makes the input-to-output latency depend on the stage parameter, and the reference model shifts its view of the inputs by that same parameter. With these widths, both transmit/receive entry modes, the 31- and 33-bit miscounts, and a frame that changes strobe level partway through can all be reached within a few thousand cycles.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;

  // Strobes from the frame controller to the register datapath
  typedef struct packed {
    logic shift;     // take one bit from each data line
    logic loadCR;    // commit a control-or-reference frame
    logic loadTxRx;  // commit a transmit/receive frame
  } progStrobe_t;

endpackage

// File: rtl/synth_prog_sync.sv
module synth_prog_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= '0;
    else       stage[0] <= asyncIn;
  end

  for (genvar g = 1; g < STAGES; g++) begin : gChain
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[g] <= '0;
      else       stage[g] <= stage[g-1];
    end
  end

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/synth_prog_ctrl.sv
module synth_prog_ctrl
  import synth_prog_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sClk,
  input  logic        sEnb,
  input  logic        dualLine,
  output progStrobe_t strb,
  output logic        loadErr
);

  localparam int CNT_BITS = $clog2(WORD_W + 2);
  localparam logic [CNT_BITS-1:0] FULL_CNT = CNT_BITS'(WORD_W);
  localparam logic [CNT_BITS-1:0] HALF_CNT = CNT_BITS'(CNT_W);
  localparam logic [CNT_BITS-1:0] SAT_CNT  = CNT_BITS'(WORD_W + 1);

  logic                clkPrev, enbPrev;
  logic [CNT_BITS-1:0] bitCnt;
  logic                modeHigh, mixed;
  logic                clkRise, enbFall, frameOk, haveBits;
  logic [CNT_BITS-1:0] needCnt;

  assign clkRise  = sClk & ~clkPrev;
  assign enbFall  = ~sEnb & enbPrev;
  assign haveBits = (bitCnt != '0);
  assign needCnt  = (modeHigh || !dualLine) ? FULL_CNT : HALF_CNT;
  assign frameOk  = !mixed && (bitCnt == needCnt);

  always_comb begin
    strb          = '0;
    strb.shift    = clkRise;
    strb.loadCR   = enbFall && haveBits && frameOk && modeHigh;
    strb.loadTxRx = enbFall && haveBits && frameOk && !modeHigh;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev  <= 1'b0;
      enbPrev  <= 1'b0;
      bitCnt   <= '0;
      modeHigh <= 1'b0;
      mixed    <= 1'b0;
      loadErr  <= 1'b0;
    end else begin
      clkPrev <= sClk;
      enbPrev <= sEnb;
      loadErr <= enbFall && haveBits && !frameOk;
      if (enbFall) begin
        bitCnt <= '0;
        mixed  <= 1'b0;
      end else if (clkRise) begin
        if (!haveBits)             modeHigh <= sEnb;
        else if (sEnb != modeHigh) mixed    <= 1'b1;
        if (bitCnt != SAT_CNT)     bitCnt   <= bitCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/synth_prog_regs.sv
module synth_prog_regs
  import synth_prog_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 16,
  parameter int REF_W  = 12,
  parameter int AUX_W  = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  progStrobe_t       strb,
  input  logic              sData,
  input  logic              sAux,
  output logic [WORD_W-1:0] ctrlWord,
  output logic [REF_W-1:0]  refDiv,
  output logic [AUX_W-1:0]  auxDiv,
  output logic              refSel,
  output logic              auxEn,
  output logic [CNT_W-1:0]  txDiv,
  output logic [CNT_W-1:0]  rxDiv
);

  localparam int REF_LSB = 3;
  localparam int AUX_LSB = REF_LSB + REF_W;
  localparam int SEL_BIT = AUX_LSB + AUX_W;
  localparam int EN_BIT  = SEL_BIT + 1;
  localparam int TYPE_BIT = WORD_W - 1;

  logic [WORD_W-1:0] shMain;
  logic [CNT_W-1:0]  shAux;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shMain <= '0;
      shAux  <= '0;
    end else if (strb.shift) begin
      shMain <= {shMain[WORD_W-2:0], sData};
      shAux  <= {shAux[CNT_W-2:0], sAux};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlWord <= '0;
      refDiv   <= '0;
      auxDiv   <= '0;
      refSel   <= 1'b0;
      auxEn    <= 1'b0;
    end else if (strb.loadCR) begin
      if (shMain[TYPE_BIT]) begin
        ctrlWord <= shMain;
      end else begin
        auxEn  <= shMain[EN_BIT];
        refSel <= shMain[SEL_BIT];
        auxDiv <= shMain[SEL_BIT-1:AUX_LSB];
        refDiv <= shMain[AUX_LSB-1:REF_LSB];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txDiv <= '0;
      rxDiv <= '0;
    end else if (strb.loadTxRx) begin
      rxDiv <= shMain[CNT_W-1:0];
      if (ctrlWord[0]) txDiv <= shAux;
      else             txDiv <= shMain[WORD_W-1:CNT_W];
    end
  end

endmodule

// File: rtl/synth_prog_loader.sv
module synth_prog_loader
  import synth_prog_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int CNT_W       = 16,
  parameter int REF_W       = 12,
  parameter int AUX_W       = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              serEnb,
  input  logic              serData,
  input  logic              serAux,
  output logic [WORD_W-1:0] ctrlWord,
  output logic [REF_W-1:0]  refDiv,
  output logic [AUX_W-1:0]  auxDiv,
  output logic              refSel,
  output logic              auxEn,
  output logic              auxPowerDown,
  output logic [CNT_W-1:0]  txDiv,
  output logic [CNT_W-1:0]  rxDiv,
  output logic              loadErr
);

  logic [3:0]  syncBus;
  progStrobe_t strb;

  synth_prog_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({serClk, serEnb, serData, serAux}),
    .syncOut (syncBus)
  );

  synth_prog_ctrl #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sClk     (syncBus[3]),
    .sEnb     (syncBus[2]),
    .dualLine (ctrlWord[0]),
    .strb     (strb),
    .loadErr  (loadErr)
  );

  synth_prog_regs #(.WORD_W(WORD_W), .CNT_W(CNT_W), .REF_W(REF_W), .AUX_W(AUX_W)) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .sData    (syncBus[1]),
    .sAux     (syncBus[0]),
    .ctrlWord (ctrlWord),
    .refDiv   (refDiv),
    .auxDiv   (auxDiv),
    .refSel   (refSel),
    .auxEn    (auxEn),
    .txDiv    (txDiv),
    .rxDiv    (rxDiv)
  );

  assign auxPowerDown = ~auxEn;

endmodule

// File: rtl/synth_prog_checker.sv
module synth_prog_checker #(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 16,
  parameter int REF_W  = 12,
  parameter int AUX_W  = 14
) (
  input logic              clk,
  input logic              rstN,
  input logic              anyLoad,
  input logic              loadErr,
  input logic [WORD_W-1:0] ctrlWord,
  input logic [REF_W-1:0]  refDiv,
  input logic [AUX_W-1:0]  auxDiv,
  input logic [CNT_W-1:0]  txDiv,
  input logic [CNT_W-1:0]  rxDiv
);

  assert_err_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    loadErr |=> !loadErr);

  assert_err_discards_R9: assert property (@(posedge clk) disable iff (!rstN)
    loadErr |-> ($stable(ctrlWord) && $stable(refDiv) && $stable(auxDiv)
                 && $stable(txDiv) && $stable(rxDiv)));

  assert_change_needs_load_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(ctrlWord) || !$stable(refDiv) || !$stable(auxDiv)
     || !$stable(txDiv) || !$stable(rxDiv)) |-> $past(anyLoad));

  assert_txrx_keeps_cr_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(txDiv) || !$stable(rxDiv))
      |-> ($stable(ctrlWord) && $stable(refDiv) && $stable(auxDiv)));

  assert_cr_keeps_txrx_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(ctrlWord) || !$stable(refDiv) || !$stable(auxDiv))
      |-> ($stable(txDiv) && $stable(rxDiv)));

endmodule

bind synth_prog_loader synth_prog_checker #(
  .WORD_W(WORD_W), .CNT_W(CNT_W), .REF_W(REF_W), .AUX_W(AUX_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .anyLoad  (strb.loadCR | strb.loadTxRx),
  .loadErr  (loadErr),
  .ctrlWord (ctrlWord),
  .refDiv   (refDiv),
  .auxDiv   (auxDiv),
  .txDiv    (txDiv),
  .rxDiv    (rxDiv)
);

// File: tb/synth_prog_loader_bench.sv
module synth_prog_loader_bench;

  localparam int SYNC = 3;
  localparam int HALF = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0, serEnb = 1'b0, serData = 1'b0, serAux = 1'b0;
  logic [31:0] ctrlWord;
  logic [11:0] refDiv;
  logic [13:0] auxDiv;
  logic        refSel, auxEn, auxPowerDown, loadErr;
  logic [15:0] txDiv, rxDiv;

  always #10 clk = ~clk;

  synth_prog_loader #(.SYNC_STAGES(SYNC)) u_synth_prog_loader (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serEnb(serEnb),
    .serData(serData), .serAux(serAux), .ctrlWord(ctrlWord),
    .refDiv(refDiv), .auxDiv(auxDiv), .refSel(refSel), .auxEn(auxEn),
    .auxPowerDown(auxPowerDown), .txDiv(txDiv), .rxDiv(rxDiv),
    .loadErr(loadErr)
  );

  int checks = 0, fails = 0, errPulses = 0, cycles = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [3:0]  hist[$];
  logic [31:0] mCtrl, mMain;
  logic [15:0] mAux, mTx, mRx;
  logic [11:0] mRef;
  logic [13:0] mAuxDiv;
  logic        mSel, mEn, mErr, mMode, mMixed;
  int          mCnt;

  task automatic modelReset();
    mCtrl = 0; mMain = 0; mAux = 0; mTx = 0; mRx = 0; mRef = 0; mAuxDiv = 0;
    mSel = 0; mEn = 0; mErr = 0; mMode = 0; mMixed = 0; mCnt = 0;
    hist.delete();
    for (int i = 0; i < SYNC + 2; i++) hist.push_front(4'b0);
  endtask

  always @(posedge clk) begin
    hist.push_front({serClk, serEnb, serData, serAux});
    if (hist.size() > SYNC + 2) void'(hist.pop_back());
  end

  always @(negedge clk) begin
    logic [3:0] cur, prv;
    int need;
    cycles++;
    if (!rstN) modelReset();
    else begin
      cur = hist[SYNC];
      prv = hist[SYNC+1];
      mErr = 0;
      if (!cur[2] && prv[2]) begin
        if (mCnt != 0) begin
          need = (mMode || !mCtrl[0]) ? 32 : 16;
          if (mMixed || mCnt != need) mErr = 1;
          else if (mMode) begin
            if (mMain[31]) mCtrl = mMain;
            else begin
              mEn = mMain[30]; mSel = mMain[29];
              mAuxDiv = mMain[28:15]; mRef = mMain[14:3];
            end
          end else begin
            mRx = mMain[15:0];
            mTx = mCtrl[0] ? mAux : mMain[31:16];
          end
        end
        mCnt = 0; mMixed = 0;
      end else if (cur[3] && !prv[3]) begin
        if (mCnt == 0) mMode = cur[2];
        else if (cur[2] != mMode) mMixed = 1;
        mMain = {mMain[30:0], cur[1]};
        mAux  = {mAux[14:0], cur[0]};
        if (mCnt < 33) mCnt++;
      end
    end
    if (loadErr) errPulses++;
    check("R3 ctrlWord", ctrlWord, mCtrl);
    check("R4 refDiv", {20'b0, refDiv}, {20'b0, mRef});
    check("R4 auxDiv", {18'b0, auxDiv}, {18'b0, mAuxDiv});
    check("R4 refSel/auxEn", {30'b0, refSel, auxEn}, {30'b0, mSel, mEn});
    check("R5 auxPowerDown", {31'b0, auxPowerDown}, {31'b0, ~mEn});
    check(mCtrl[0] ? "R7 tx/rx" : "R6 tx/rx", {txDiv, rxDiv}, {mTx, mRx});
    check("R9 loadErr", {31'b0, loadErr}, {31'b0, mErr});
  end

  // ---------------- stimulus ----------------
  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic d, input logic a);
    serData = d; serAux = a;
    waitCyc(HALF); serClk = 1'b1;
    waitCyc(HALF); serClk = 1'b0;
  endtask

  task automatic sendHigh(input logic [63:0] w, input int n);
    serEnb = 1'b1; waitCyc(HALF);
    for (int i = n - 1; i >= 0; i--) sendBit(w[i], 1'b0);
    waitCyc(HALF); serEnb = 1'b0; waitCyc(2 * HALF + SYNC);
  endtask

  task automatic sendLow(input logic [63:0] d, input logic [15:0] a, input int n);
    serEnb = 1'b0;
    for (int i = n - 1; i >= 0; i--) sendBit(d[i], (i < 16) ? a[i] : 1'b0);
    waitCyc(HALF); serEnb = 1'b1; waitCyc(HALF); serEnb = 1'b0;
    waitCyc(2 * HALF + SYNC);
  endtask

  task automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(negedge clk) begin
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    int e0;
    modelReset();
    waitCyc(4);
    // R1: reset state
    check("R1 reset regs", ctrlWord | txDiv | rxDiv | refDiv, 32'h0);
    check("R1 reset pd", {31'b0, auxPowerDown}, 32'h1);
    rstN = 1'b1;
    waitCyc(4);

    // R4/R2: reference word, MSB first
    sendHigh({32'h0, 1'b0, 1'b1, 1'b1, 14'h2A5B, 12'hABC, 3'b101}, 32);
    check("R2 R4 ref fields", {auxEn, refSel, auxDiv, refDiv, 4'h0},
          {1'b1, 1'b1, 14'h2A5B, 12'hABC, 4'h0});
    check("R5 pd low", {31'b0, auxPowerDown}, 32'h0);

    // R3: control word, single-line mode
    sendHigh({32'h0, 32'h8000_1230}, 32);
    check("R3 ctrl", ctrlWord, 32'h8000_1230);

    // R6: 32-bit single line
    sendLow({32'h0, 16'h1234, 16'hBEEF}, 16'h0, 32);
    check("R6 tx", {16'h0, txDiv}, 32'h1234);
    check("R6 rx", {16'h0, rxDiv}, 32'hBEEF);
    check("R8 ctrl kept", ctrlWord, 32'h8000_1230);
    check("R8 ref kept", {20'h0, refDiv}, 32'hABC);

    // R9: short frame
    e0 = errPulses;
    sendLow({32'h0, 32'hFFFF_FFFF}, 16'h0, 31);
    check("R9 short err", errPulses - e0, 1);
    check("R9 short kept", {txDiv, rxDiv}, 32'h1234_BEEF);

    // R10: bare strobe pulse
    e0 = errPulses;
    serEnb = 1'b1; waitCyc(HALF); serEnb = 1'b0; waitCyc(2 * HALF + SYNC);
    check("R10 no err", errPulses - e0, 0);
    check("R10 kept", {txDiv, rxDiv}, 32'h1234_BEEF);

    // R7: two-line mode
    sendHigh({32'h0, 32'h8000_0001}, 32);
    sendLow({48'h0, 16'h0F1E}, 16'hA5C3, 16);
    check("R7 tx", {16'h0, txDiv}, 32'hA5C3);
    check("R7 rx", {16'h0, rxDiv}, 32'h0F1E);

    // R9: 32 bits in two-line mode
    e0 = errPulses;
    sendLow({32'h0, 32'h5555_AAAA}, 16'h1111, 32);
    check("R9 long err", errPulses - e0, 1);
    check("R9 long kept", {txDiv, rxDiv}, 32'hA5C3_0F1E);

    // R5/R8: reference with aux disabled
    sendHigh({32'h0, 1'b0, 1'b0, 1'b0, 14'h0123, 12'h456, 3'b000}, 32);
    check("R5 pd high", {31'b0, auxPowerDown}, 32'h1);
    check("R8 tx kept", {txDiv, rxDiv}, 32'hA5C3_0F1E);

    // R9: control path 33 bits and 31 bits
    e0 = errPulses;
    sendHigh({31'h0, 33'h1_0000_0000}, 33);
    sendHigh({32'h0, 32'hC000_0000}, 31);
    check("R9 cr miscount", errPulses - e0, 2);
    check("R9 ctrl kept", ctrlWord, 32'h8000_0001);

    // R9: mixed strobe levels
    e0 = errPulses;
    serEnb = 1'b0;
    for (int i = 0; i < 8; i++) sendBit(1'b1, 1'b1);
    serEnb = 1'b1; waitCyc(HALF);
    for (int i = 0; i < 8; i++) sendBit(1'b0, 1'b0);
    waitCyc(HALF); serEnb = 1'b0; waitCyc(2 * HALF + SYNC);
    check("R9 mixed err", errPulses - e0, 1);
    check("R9 mixed kept", {txDiv, rxDiv}, 32'hA5C3_0F1E);

    waitCyc(10);
    finishRun();
  end

endmodule